// File: doc/BRIEF.md
# I2C Interrupt and Error Flag Logic

This block sits beside the byte engine of an I2C controller and turns its status into two level interrupt lines: one for bus events (start sent, address phase done, byte finished, transmit buffer empty, receive buffer full) and one for bus errors (bus error, arbitration lost, acknowledge failure). Three enable bits in the control register gate the lines. The buffer flags reach the event line only when a separate buffer enable is set along with the event enable. This lets software take per-byte interrupts or only the coarser phase events.

The event flags follow the engine's level outputs and are read-only in the status register. The three error flags are sticky. A one-cycle pulse from the engine sets an error flag. Software clears it by writing 0 to its bit in the status register, and writing 1 leaves it as it is. Both registers are always visible on output ports. A single write strobe with a register select updates either the control register or the error flags.

Top module: `i2c_irq_flags`

## Requirements
- R1: After reset the control register, the status register, `irq_evt` and `irq_err` are all zero.
- R2: A write with `reg_sel`=0 stores `wr_data[5:0]` (clock frequency in MHz) and the enables error-enable (bit 8), event-enable (bit 9) and buffer-enable (bit 10). All other control bits read 0. The value is visible on `ctrl_q` the cycle after the write.
- R3: `irq_evt` is high when event-enable is set and any of start-sent (status bit 0), address-done (bit 1) or byte-finished (bit 2) is set.
- R4: Transmit-empty (status bit 7) and receive-full (status bit 6) raise `irq_evt` only when both buffer-enable and event-enable are set.
- R5: A one-cycle pulse on `set_berr`, `set_arlo` or `set_af` sets status bit 8, 9 or 10 respectively. The bit stays set until it is cleared.
- R6: A write with `reg_sel`=1 clears each error flag whose bit in `wr_data` is 0. A 1 in that bit leaves the flag unchanged.
- R7: When a set pulse and a clearing write hit the same error flag in the same cycle, the flag ends up set.
- R8: `irq_err` is high exactly when error-enable is set and at least one error flag is set.
- R9: Writes to the status register do not change the event bits 0, 1, 2, 6 and 7, nor any other bit outside 8 to 10.
- R10: Each event bit in `stat_q` shows the matching engine input one cycle after that input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Engine: start condition sent |
| ev_addr | input | 1 | Engine: address phase done |
| ev_btf | input | 1 | Engine: byte transfer finished |
| ev_txe | input | 1 | Engine: transmit buffer empty |
| ev_rxne | input | 1 | Engine: receive buffer holds a byte |
| set_berr | input | 1 | Pulse: bus error seen |
| set_arlo | input | 1 | Pulse: arbitration lost |
| set_af | input | 1 | Pulse: acknowledge failure |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = status register |
| wr_data | input | 16 | Write data |
| ctrl_q | output | 16 | Control register contents |
| stat_q | output | 16 | Status register contents |
| irq_evt | output | 1 | Event interrupt (level) |
| irq_err | output | 1 | Error interrupt (level) |

## Verification
Every result is due one clock edge after its stimulus. A register write, an error pulse or an engine level change is captured at the next rising edge, and both interrupt lines follow the registers with no further delay. The bench therefore drives each stimulus at a falling edge and samples one nanosecond after the following rising edge. Collision and read-only cases hold the competing input across the same edge, so the check shows which source won.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int REG_W   = 16;
  localparam int FREQ_W  = 6;
  localparam int NUM_ERR = 3;

  // control register bit positions
  localparam int CB_ERR_EN = 8;
  localparam int CB_EVT_EN = 9;
  localparam int CB_BUF_EN = 10;

  // status register bit positions
  localparam int SB_START = 0;
  localparam int SB_ADDR  = 1;
  localparam int SB_BTF   = 2;
  localparam int SB_RXNE  = 6;
  localparam int SB_TXE   = 7;
  localparam int SB_BERR  = 8;   // error flags occupy SB_BERR .. SB_BERR+NUM_ERR-1
  localparam int SB_ARLO  = 9;
  localparam int SB_AF    = 10;

  typedef struct packed {
    logic buf_en;
    logic evt_en;
    logic err_en;
  } irq_en_t;

  typedef struct packed {
    logic txe;
    logic rxne;
    logic btf;
    logic addr;
    logic start;
  } evt_flags_t;

  function automatic logic [REG_W-1:0] ctrl_mask_f();
    logic [REG_W-1:0] m;
    m = '0;
    m[FREQ_W-1:0] = '1;
    m[CB_ERR_EN]  = 1'b1;
    m[CB_EVT_EN]  = 1'b1;
    m[CB_BUF_EN]  = 1'b1;
    return m;
  endfunction

  function automatic logic evt_irq_f(irq_en_t en, evt_flags_t f);
    logic phase_ev;
    logic buf_ev;
    phase_ev = f.start | f.addr | f.btf;
    buf_ev   = en.buf_en & (f.txe | f.rxne);
    return en.evt_en & (phase_ev | buf_ev);
  endfunction

  function automatic logic err_irq_f(irq_en_t en, logic [NUM_ERR-1:0] e);
    return en.err_en & (|e);
  endfunction
endpackage

// File: rtl/i2c_ctrl_reg.sv
module i2c_ctrl_reg
  import i2c_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_q,
  output irq_en_t          en,
  output logic [FREQ_W-1:0] freq
);
  localparam logic [REG_W-1:0] MASK = ctrl_mask_f();

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata & MASK;
  end

  assign en.err_en = ctrl_q[CB_ERR_EN];
  assign en.evt_en = ctrl_q[CB_EVT_EN];
  assign en.buf_en = ctrl_q[CB_BUF_EN];
  assign freq      = ctrl_q[FREQ_W-1:0];

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/i2c_err_flags.sv
module i2c_err_flags
  import i2c_irq_pkg::*;
#(
  parameter int N = NUM_ERR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_pulse,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_data,
  output logic [N-1:0] flags
);
  logic [N-1:0] clr_hit;

  for (genvar i = 0; i < N; i++) begin : g_flag
    assign clr_hit[i] = clr_wr & ~clr_data[i];

    always_ff @(posedge clk) begin
      if (!rst_n)            flags[i] <= 1'b0;
      else if (set_pulse[i]) flags[i] <= 1'b1;   // set wins over clear
      else if (clr_hit[i])   flags[i] <= 1'b0;
    end

    // R5 R7
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_pulse[i] |=> flags[i]);
    // R6
    err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_data[i] && !set_pulse[i]) |=> $stable(flags[i]));
    // R6
    err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[i] && !set_pulse[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/i2c_irq_combine.sv
module i2c_irq_combine
  import i2c_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  irq_en_t            en,
  input  evt_flags_t         evt,
  input  logic [NUM_ERR-1:0] err,
  output logic               irq_evt,
  output logic               irq_err
);
  logic phase_any;
  assign phase_any = evt.start | evt.addr | evt.btf;

  assign irq_evt = evt_irq_f(en, evt);
  assign irq_err = err_irq_f(en, err);

  // R3
  evt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt |-> en.evt_en);
  // R4
  buf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt && !phase_any) |-> en.buf_en);
  // R8
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err |-> (en.err_en && err != '0));
endmodule

// File: rtl/i2c_irq_flags.sv
module i2c_irq_flags
  import i2c_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start,
  input  logic             ev_addr,
  input  logic             ev_btf,
  input  logic             ev_txe,
  input  logic             ev_rxne,
  input  logic             set_berr,
  input  logic             set_arlo,
  input  logic             set_af,
  input  logic             wr_en,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctrl_q,
  output logic [REG_W-1:0] stat_q,
  output logic             irq_evt,
  output logic             irq_err
);
  logic               wr_ctrl, wr_stat;
  irq_en_t            en;
  logic [FREQ_W-1:0]  freq;
  evt_flags_t         evt_d, evt_q;
  logic [NUM_ERR-1:0] err_set, err_q;

  assign wr_ctrl = wr_en & ~reg_sel;
  assign wr_stat = wr_en &  reg_sel;

  assign evt_d   = '{txe: ev_txe, rxne: ev_rxne, btf: ev_btf, addr: ev_addr, start: ev_start};
  assign err_set = {set_af, set_arlo, set_berr};

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  i2c_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(wr_data),
    .ctrl_q(ctrl_q), .en(en), .freq(freq)
  );

  i2c_err_flags #(.N(NUM_ERR)) u_err (
    .clk(clk), .rst_n(rst_n), .set_pulse(err_set), .clr_wr(wr_stat),
    .clr_data(wr_data[SB_BERR +: NUM_ERR]), .flags(err_q)
  );

  i2c_irq_combine u_comb (
    .clk(clk), .rst_n(rst_n), .en(en), .evt(evt_q), .err(err_q),
    .irq_evt(irq_evt), .irq_err(irq_err)
  );

  always_comb begin
    stat_q = '0;
    stat_q[SB_START] = evt_q.start;
    stat_q[SB_ADDR]  = evt_q.addr;
    stat_q[SB_BTF]   = evt_q.btf;
    stat_q[SB_RXNE]  = evt_q.rxne;
    stat_q[SB_TXE]   = evt_q.txe;
    stat_q[SB_BERR +: NUM_ERR] = err_q;
  end

  // R9
  stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && $stable(evt_d)) |=> $stable(stat_q[SB_TXE:SB_START]));
  // R1
  freq_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (freq == '0 && !irq_evt && !irq_err));
endmodule

// File: tb/i2c_irq_flags_tb.sv
`timescale 1ns/1ps
module i2c_irq_flags_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start = 0, ev_addr = 0, ev_btf = 0, ev_txe = 0, ev_rxne = 0;
  logic set_berr = 0, set_arlo = 0, set_af = 0;
  logic wr_en = 0, reg_sel = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] ctrl_q, stat_q;
  logic irq_evt, irq_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_irq_flags u_dut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_addr(ev_addr),
    .ev_btf(ev_btf), .ev_txe(ev_txe), .ev_rxne(ev_rxne),
    .set_berr(set_berr), .set_arlo(set_arlo), .set_af(set_af),
    .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .irq_evt(irq_evt), .irq_err(irq_err)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample 1 ns after the next rising edge
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic sel, logic [15:0] d);
    @(negedge clk); wr_en = 1; reg_sel = sel; wr_data = d;
    step();
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic t_reset();
    chk("R1 ctrl", ctrl_q, 16'h0000);
    chk("R1 stat", stat_q, 16'h0000);
    chk("R1 irqs", {14'd0, irq_evt, irq_err}, 16'h0000);
  endtask

  task automatic t_ctrl();
    wr(1'b0, 16'hFFFF);
    chk("R2 mask", ctrl_q, 16'h073F);
    wr(1'b0, 16'h0215);
    chk("R2 value", ctrl_q, 16'h0215);
    wr(1'b0, 16'h0000);
    chk("R2 zero", ctrl_q, 16'h0000);
  endtask

  task automatic t_evt();
    wr(1'b0, 16'h0000);
    @(negedge clk); ev_start = 1; step();
    chk("R10 start bit", stat_q, 16'h0001);
    chk("R3 no enable", {15'd0, irq_evt}, 16'h0);
    wr(1'b0, 16'h0200);
    chk("R3 start", {15'd0, irq_evt}, 16'h1);
    @(negedge clk); ev_start = 0; ev_addr = 1; step();
    chk("R10 addr bit", stat_q, 16'h0002);
    chk("R3 addr", {15'd0, irq_evt}, 16'h1);
    @(negedge clk); ev_addr = 0; ev_btf = 1; step();
    chk("R3 btf", {15'd0, irq_evt}, 16'h1);
    @(negedge clk); ev_btf = 0; step();
    chk("R3 idle", {15'd0, irq_evt}, 16'h0);
  endtask

  task automatic t_buf();
    wr(1'b0, 16'h0200);
    @(negedge clk); ev_txe = 1; step();
    chk("R10 txe bit", stat_q, 16'h0080);
    chk("R4 txe no buf", {15'd0, irq_evt}, 16'h0);
    wr(1'b0, 16'h0600);
    chk("R4 txe buf", {15'd0, irq_evt}, 16'h1);
    @(negedge clk); ev_txe = 0; ev_rxne = 1; step();
    chk("R4 rxne buf", {15'd0, irq_evt}, 16'h1);
    wr(1'b0, 16'h0400);
    chk("R4 buf without evt", {15'd0, irq_evt}, 16'h0);
    @(negedge clk); ev_rxne = 0; step();
    wr(1'b0, 16'h0000);
  endtask

  task automatic t_err();
    @(negedge clk); set_arlo = 1; step();
    @(negedge clk); set_arlo = 0; step(); step();
    chk("R5 arlo sticky", stat_q, 16'h0200);
    chk("R8 no enable", {15'd0, irq_err}, 16'h0);
    wr(1'b0, 16'h0100);
    chk("R8 err irq", {15'd0, irq_err}, 16'h1);
    @(negedge clk); set_berr = 1; step();
    @(negedge clk); set_berr = 0;
    chk("R5 berr", stat_q, 16'h0300);
  endtask

  task automatic t_clear();
    wr(1'b1, 16'hFFFF);
    chk("R6 write ones", stat_q, 16'h0300);
    wr(1'b1, 16'hFDFF);
    chk("R6 clear arlo", stat_q, 16'h0100);
    chk("R8 still err", {15'd0, irq_err}, 16'h1);
    wr(1'b1, 16'h0000);
    chk("R6 clear all", stat_q, 16'h0000);
    chk("R8 err low", {15'd0, irq_err}, 16'h0);
  endtask

  task automatic t_collide();
    @(negedge clk); set_af = 1; wr_en = 1; reg_sel = 1; wr_data = 16'h0000;
    step();
    @(negedge clk); set_af = 0; wr_en = 0;
    chk("R7 set wins", stat_q, 16'h0400);
    wr(1'b1, 16'h0000);
    chk("R7 later clear", stat_q, 16'h0000);
  endtask

  task automatic t_ro();
    @(negedge clk); ev_btf = 1; step();
    wr(1'b1, 16'h0000);
    chk("R9 btf kept", stat_q, 16'h0004);
    @(negedge clk); ev_btf = 0; step();
    wr(1'b1, 16'hF8FF);
    chk("R9 ro bits", stat_q, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    t_reset();
    t_ctrl();
    t_evt();
    t_buf();
    t_err();
    t_clear();
    t_collide();
    t_ro();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule